// File: doc/BRIEF.md
# Neighbour-Coincidence Dual-Level Trigger

This block watches a row of digitized photodetector channels, twelve by default, each delivering one 12-bit sample per clock. Every channel is compared against two shared programmable levels, a low level and a high level. A rising crossing of either level opens a request window of programmable length for that channel and level. The block emits the per-channel low and high request vectors as they stand.

A section trigger needs physical coincidence. Some channel must hold a high request while a channel directly beside it in the linear ordering holds a low request. The row does not wrap, so the first and last channels each have only one neighbour. When a coincidence is found, the block issues a one-cycle trigger pulse together with the index of the high-request channel. A programmable dead time then blocks further triggers.

The levels, window length and dead time are loaded through a small write port with a 2-bit address.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is held and directly after it, all low and high requests and the trigger pulse are 0 and the channel index is 0. The reset configuration has both levels at 4095, the window at 1 and the dead time at 0, so no request can be raised until the levels are written.
- R2: A channel's low request rises in the cycle after the clock edge that captures a sample strictly greater than the low level, when the previous sample of that channel was not above it. It stays high for exactly W cycles. The low level is written at address 0 from data bits [11:0].
- R3: The high request follows the same rule against the high level, which is written at address 1. The two comparisons are independent: a low level above the high level is accepted, and a sample between the two raises only the high request.
- R4: A sample that stays above a level does not restart its window. After the sample drops to or below the level, a new crossing restarts the full window.
- R5: The window W is written at address 2 from data bits [5:0]. A written value of 0 is stored as 1.
- R6: A trigger is formed when channel i holds a high request while channel i-1 or channel i+1 holds a low request. A high and low request on the same channel alone do not trigger.
- R7: Channel 0 and the last channel are not neighbours. A high request on one of them paired with a low request only on the other gives no trigger.
- R8: The trigger pulse is one cycle wide and appears one clock edge after the requests that form it. The channel index output gives the lowest channel index that qualifies in that cycle.
- R9: The dead time M is written at address 3 from data bits [11:0]. With a coincidence present continuously, consecutive trigger pulses are exactly max(M,1)+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | NUM_CH*12 | Packed samples, channel i in bits [12*i+11:12*i] |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration address: 0 low level, 1 high level, 2 window, 3 dead time |
| cfgData | input | 12 | Configuration write data |
| lowReq | output | NUM_CH | Per-channel low requests |
| highReq | output | NUM_CH | Per-channel high requests |
| trigPulse | output | 1 | One-cycle section trigger |
| trigChan | output | clog2(NUM_CH) | Index of the high-request channel that fired |

## Verification
The assertions assume that the configuration port stores a zero window as one and that reset is applied long enough for every register to clear. They also assume that the trigger only ever reacts to the request vectors of the cycle before, so the inputs are never expected to be stable for any particular length. The stimulus changes samples and configuration only just after a clock edge, and it changes configuration only while all channels sit at zero. The stimulus also leaves enough idle cycles between scenarios for every window and dead time to expire, so each scenario starts from quiet requests.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int SAMPLE_W = 12;
  localparam int WIN_W    = 6;
  localparam int DEAD_W   = SAMPLE_W;

  typedef enum logic [1:0] {
    ADDR_LOW  = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_WIN  = 2'd2,
    ADDR_DEAD = 2'd3
  } cfgAddr_e;

  // Settings the control side hands to the comparator datapath
  typedef struct packed {
    logic [SAMPLE_W-1:0] lowThr;
    logic [SAMPLE_W-1:0] highThr;
    logic [WIN_W-1:0]    window;
  } thrCfg_t;
endpackage

// File: rtl/trig_stretch.sv
module trig_stretch
  import coinc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [WIN_W-1:0]    window,
  output logic                req
);
  logic             above;
  logic             prevAbove;
  logic [WIN_W-1:0] cnt;

  assign above = sample > level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAbove <= 1'b0;
      cnt       <= '0;
    end else begin
      prevAbove <= above;
      if (above && !prevAbove)
        cnt <= window;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign req = (cnt != '0);
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import coinc_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleIn,
  input  thrCfg_t                    cfg,
  output logic [NUM_CH-1:0]          lowReq,
  output logic [NUM_CH-1:0]          highReq
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] smp;
    assign smp = sampleIn[ch*SAMPLE_W +: SAMPLE_W];

    trig_stretch i_low (
      .clk(clk), .rstN(rstN), .sample(smp), .level(cfg.lowThr),
      .window(cfg.window), .req(lowReq[ch])
    );
    trig_stretch i_high (
      .clk(clk), .rstN(rstN), .sample(smp), .level(cfg.highThr),
      .window(cfg.window), .req(highReq[ch])
    );
  end
endmodule

// File: rtl/trig_control.sv
module trig_control
  import coinc_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgAddr,
  input  logic [SAMPLE_W-1:0] cfgData,
  input  logic [NUM_CH-1:0]   lowReq,
  input  logic [NUM_CH-1:0]   highReq,
  output thrCfg_t             cfg,
  output logic                trigPulse,
  output logic [CH_W-1:0]     trigChan
);
  logic [DEAD_W-1:0] deadTime;
  logic [DEAD_W-1:0] deadCnt;
  logic [NUM_CH-1:0] hit;
  logic [CH_W-1:0]   pick;
  logic              fire;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg.lowThr  <= '1;
      cfg.highThr <= '1;
      cfg.window  <= WIN_W'(1);
      deadTime    <= '0;
    end else if (cfgWe) begin
      case (cfgAddr_e'(cfgAddr))
        ADDR_LOW:  cfg.lowThr  <= cfgData;
        ADDR_HIGH: cfg.highThr <= cfgData;
        ADDR_WIN:  cfg.window  <= (cfgData[WIN_W-1:0] == '0) ? WIN_W'(1)
                                                              : cfgData[WIN_W-1:0];
        default:   deadTime    <= cfgData[DEAD_W-1:0];
      endcase
    end
  end

  // Neighbour coincidence, no wraparound at the row ends
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
    logic nbrLow;
    if (ch == 0) begin : g_first
      assign nbrLow = lowReq[ch+1];
    end else if (ch == NUM_CH-1) begin : g_last
      assign nbrLow = lowReq[ch-1];
    end else begin : g_mid
      assign nbrLow = lowReq[ch-1] | lowReq[ch+1];
    end
    assign hit[ch] = highReq[ch] & nbrLow;
  end

  always_comb begin
    pick = '0;
    for (int i = NUM_CH-1; i >= 0; i--)
      if (hit[i]) pick = CH_W'(i);
  end

  assign fire = (|hit) && (deadCnt == '0) && !trigPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigPulse <= 1'b0;
      trigChan  <= '0;
      deadCnt   <= '0;
    end else begin
      trigPulse <= fire;
      if (fire) begin
        trigChan <= pick;
        deadCnt  <= deadTime;
      end else if (deadCnt != '0) begin
        deadCnt <= deadCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleIn,
  input  logic                       cfgWe,
  input  logic [1:0]                 cfgAddr,
  input  logic [SAMPLE_W-1:0]        cfgData,
  output logic [NUM_CH-1:0]          lowReq,
  output logic [NUM_CH-1:0]          highReq,
  output logic                       trigPulse,
  output logic [CH_W-1:0]            trigChan
);
  thrCfg_t cfgBus;

  trig_control #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .lowReq(lowReq), .highReq(highReq), .cfg(cfgBus),
    .trigPulse(trigPulse), .trigChan(trigChan)
  );

  trig_datapath #(.NUM_CH(NUM_CH)) i_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .cfg(cfgBus),
    .lowReq(lowReq), .highReq(highReq)
  );
endmodule

// File: rtl/coinc_checker.sv
module coinc_checker
  import coinc_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] lowReq,
  input logic [NUM_CH-1:0] highReq,
  input logic              trigPulse,
  input logic [CH_W-1:0]   trigChan,
  input thrCfg_t           cfg
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);                                            // R8
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (int'(trigChan) < NUM_CH));                             // R8
  AST_COINC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(|(highReq & ((lowReq << 1) | (lowReq >> 1)))));   // R6
  AST_FIRST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && trigChan == '0) |-> $past(highReq[0] && lowReq[1]));   // R7
  AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfg.window != '0);                                                    // R5
endmodule

bind coinc_trigger coinc_checker #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rstN(rstN), .lowReq(lowReq), .highReq(highReq),
  .trigPulse(trigPulse), .trigChan(trigChan), .cfg(cfgBus)
);

// File: tb/test_coinc_trigger.sv
module test_coinc_trigger;
  localparam int NCH = 12;
  localparam int SW  = 12;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH*SW-1:0] sampleIn;
  logic            cfgWe = 1'b0;
  logic [1:0]      cfgAddr = '0;
  logic [SW-1:0]   cfgData = '0;
  logic [NCH-1:0]  lowReq, highReq;
  logic            trigPulse;
  logic [3:0]      trigChan;
  logic [SW-1:0]   smp [NCH];
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb
    for (int i = 0; i < NCH; i++) sampleIn[i*SW +: SW] = smp[i];

  coinc_trigger i_coinc_trigger (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .lowReq(lowReq), .highReq(highReq),
    .trigPulse(trigPulse), .trigChan(trigChan)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // step one edge, then settle
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = SW'(d);
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < NCH; i++) smp[i] = '0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NCH; i++) smp[i] = 12'd4000;
    tick(); tick();
    chk(lowReq == 0 && highReq == 0, "R1 requests in reset", int'(lowReq | highReq), 0);
    chk(!trigPulse && trigChan == 0, "R1 trigger in reset", int'(trigPulse), 0);
    rstN = 1'b1;
    tick(); tick();
    chk(lowReq == 0 && highReq == 0, "R1 default levels raise nothing", int'(lowReq), 0);
    idle(3);
  endtask

  task automatic t_window();
    wr(2'd0, 100); wr(2'd1, 4000); wr(2'd2, 3); wr(2'd3, 100);
    smp[3] = 12'd200;
    tick();
    chk(lowReq[3], "R2 low request after crossing", int'(lowReq[3]), 1);
    chk(!highReq[3], "R3 high stays low below high level", int'(highReq[3]), 0);
    tick(); tick();
    chk(lowReq[3], "R2 low request held W cycles", int'(lowReq[3]), 1);
    tick();
    chk(!lowReq[3], "R2 low request ends after W", int'(lowReq[3]), 0);
    tick(); tick(); tick();
    chk(!lowReq[3], "R4 held level does not retrigger", int'(lowReq[3]), 0);
    smp[3] = 12'd100;
    tick();
    smp[3] = 12'd150;
    tick();
    chk(lowReq[3], "R4 recrossing restarts window", int'(lowReq[3]), 1);
    idle(8);
    wr(2'd2, 0);
    smp[7] = 12'd300;
    tick();
    chk(lowReq[7], "R5 zero window acts as one (on)", int'(lowReq[7]), 1);
    tick();
    chk(!lowReq[7], "R5 zero window acts as one (off)", int'(lowReq[7]), 0);
    idle(8);
  endtask

  task automatic t_inverted();
    wr(2'd0, 1500); wr(2'd1, 500); wr(2'd2, 4);
    smp[1] = 12'd800;
    tick();
    chk(highReq[1] && !lowReq[1], "R3 inverted levels compare independently",
        int'({highReq[1], lowReq[1]}), 2);
    idle(8);
  endtask

  // run n cycles from current stimulus, return first pulse cycle and count
  task automatic watch(input int n, output int first, output int second, output int cnt);
    first = -1; second = -1; cnt = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (trigPulse) begin
        if (cnt == 0) first = i; else if (cnt == 1) second = i;
        cnt++;
      end
    end
  endtask

  task automatic t_coinc();
    int f, s, c;
    wr(2'd0, 100); wr(2'd1, 1000); wr(2'd2, 4); wr(2'd3, 100);
    smp[5] = 12'd2000; smp[6] = 12'd200;
    watch(6, f, s, c);
    chk(f == 1, "R8 pulse one edge after requests", f, 1);
    chk(c == 1, "R6 one trigger for one coincidence", c, 1);
    idle(110);
    smp[5] = 12'd2000; smp[6] = 12'd200;
    tick(); tick();
    chk(trigPulse && trigChan == 5, "R6 index of high channel", int'(trigChan), 5);
    tick();
    chk(!trigPulse, "R8 pulse one cycle wide", int'(trigPulse), 0);
    idle(110);
    smp[4] = 12'd2000;
    watch(6, f, s, c);
    chk(c == 0, "R6 same-channel low and high do not trigger", c, 0);
    idle(110);
    smp[0] = 12'd2000; smp[11] = 12'd200;
    watch(6, f, s, c);
    chk(c == 0, "R7 no wrap from first to last channel", c, 0);
    idle(110);
    smp[11] = 12'd2000; smp[0] = 12'd200;
    watch(6, f, s, c);
    chk(c == 0, "R7 no wrap from last to first channel", c, 0);
    idle(110);
    smp[11] = 12'd2000; smp[10] = 12'd200;
    tick(); tick();
    chk(trigPulse && trigChan == 11, "R7 last channel with its neighbour", int'(trigChan), 11);
    idle(110);
    smp[8] = 12'd2000; smp[9] = 12'd200; smp[2] = 12'd2000; smp[3] = 12'd200;
    tick(); tick();
    chk(trigPulse && trigChan == 2, "R8 lowest qualifying channel wins", int'(trigChan), 2);
    idle(110);
  endtask

  task automatic t_dead();
    int f, s, c;
    wr(2'd2, 63); wr(2'd3, 5);
    smp[5] = 12'd2000; smp[6] = 12'd200;
    watch(30, f, s, c);
    chk(s - f == 6, "R9 spacing M+1 with M=5", s - f, 6);
    idle(70);
    wr(2'd3, 0);
    smp[5] = 12'd2000; smp[6] = 12'd200;
    watch(20, f, s, c);
    chk(s - f == 2, "R9 spacing 2 with M=0", s - f, 2);
    chk(c == 10, "R9 pulse count with M=0", c, 10);
    idle(70);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) smp[i] = '0;
    t_reset();
    t_window();
    t_inverted();
    t_coinc();
    t_dead();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule